// File: doc/BRIEF.md
# Serial Bus Control and Detection Register

This block is the control and status register of a clocked two-wire serial bus controller. Software writes it a byte at a time or a bit at a time. Three of its bits are one-shot triggers. The first drives the serial output latch high to signal a bus release. The second drives the latch low to signal a command. The third asks for an acknowledge on the next serial clock falling edge. Each trigger acts once and then drops back to zero.

The block also watches the bus. It resynchronises the serial clock and the data line, and it flags three conditions:
- a bus release, which is the data line rising while the clock is high;
- a command, which is the data line falling while the clock is high;
- an acknowledge, which is the data line low at the ninth rising clock edge of a transfer.

Each flag has its own set of clear sources: a transfer-start strobe, a release event, a failed address comparison while wake-up mode is on, and turning the interface off. An automatic-acknowledge enable makes the block pull the line low for the ninth clock of every transfer. If software sets that enable after the eighth bit has already been clocked, the acknowledge is driven on the very next falling edge.

The shift register, the address comparator and the baud logic sit outside this block. They reach it only through strobes.

Top module: `sbusCtrlStatus`

## Requirements
- R1: After reset, rdData reads 8'h00 and sdOut is 1.
- R2: Register layout: bit 0 release trigger, bit 1 command trigger, bit 2 acknowledge trigger, bit 3 auto-acknowledge enable, bit 4 release seen, bit 5 command seen, bit 6 acknowledge seen, bit 7 general read/write bit. After a byte write, rdData equals the written value ANDed with 8'h88: the trigger bits read 0 and bits 4 to 6 ignore writes.
- R3: A bit write (wrBit, bitSel, bitVal) changes only the selected bit.
- R4: Writing 1 to bit 0 sets the output latch to 1 in the cycle after the write. If bits 0 and 1 are written together, the latch becomes 1. A release trigger also wins over a shift-data load in the same cycle.
- R5: Writing 1 to bit 1 clears the output latch in the cycle after the write. A command trigger wins over a shift-data load in the same cycle.
- R6: While ifEnable is 0, trigger writes have no effect on sdOut.
- R7: Bit 4 sets when the data line rises while the clock is high. It clears on xferStart. It also clears on addrChk with addrMatch=0 and wakeMode=1; a check that matches, or a check made with wakeMode=0, leaves it set.
- R8: Bit 5 sets when the data line falls while the clock is high. It clears on xferStart and on a release event.
- R9: With bit 3 set before the transfer, sdOut is 0 from the 9th serial clock falling edge after xferStart until the 10th. With bit 3 clear, sdOut stays 1 over the same window.
- R10: Writing 1 to bit 2 drives sdOut to 0 from the next serial clock falling edge until the one after it. The bit reads 0 throughout.
- R11: If bit 3 goes 0 to 1 by a write after 8 or more rising edges of the transfer, sdOut is 0 from the next falling edge for one clock period, and bit 3 stays 1 afterwards. The same write after fewer than 8 rising edges drives nothing on the next falling edge.
- R12: Bit 6 sets when the data line is low at the 9th rising clock edge after xferStart. It stays 0 when the line is high there.
- R13: While ifEnable is 0, bits 4, 5 and 6 are cleared and no trigger or acknowledge is active.
- R14: With no trigger or acknowledge active, a shiftStep pulse loads shiftBit into the output latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrByte | input | 1 | Whole-register write strobe |
| wrBit | input | 1 | Single-bit write strobe |
| wrData | input | 8 | Byte write data |
| bitSel | input | 3 | Bit index for a single-bit write |
| bitVal | input | 1 | Value for a single-bit write |
| rdData | output | 8 | Register read value |
| sclIn | input | 1 | Serial clock line, asynchronous |
| sdaIn | input | 1 | Serial data line, asynchronous |
| shiftStep | input | 1 | Shift register presents a new output bit |
| shiftBit | input | 1 | Output bit from the shift register |
| xferStart | input | 1 | Transfer-start strobe |
| addrChk | input | 1 | Address comparison result is valid |
| addrMatch | input | 1 | Address comparison matched |
| wakeMode | input | 1 | Wake-up (address reception) mode |
| ifEnable | input | 1 | Serial interface enable |
| sdOut | output | 1 | Serial output latch value |

## Verification
A register write is visible on rdData one clock edge after it is captured. A trigger reaches sdOut one edge later still, so the bench samples two negative edges after raising a write strobe. Anything derived from the bus lines needs three edges: two synchroniser stages, then the edge-detect and flag registers. For that reason the bench holds each line change for four clock periods before it checks a flag or the acknowledge drive. Data-line changes are placed only while the serial clock is low, so the only release or command events are the ones a test asks for.

// File: rtl/sbusPkg.sv
package sbusPkg;
  localparam int REG_W = 8;
  localparam int REL_TRIG = 0;
  localparam int CMD_TRIG = 1;
  localparam int ACK_TRIG = 2;
  localparam int ACK_AUTO = 3;
  localparam int REL_SEEN = 4;
  localparam int CMD_SEEN = 5;
  localparam int ACK_SEEN = 6;
  localparam int GP_BIT   = 7;

  typedef struct packed {
    logic forceHigh;
    logic forceLow;
    logic ackLow;
  } drvStrobes_t;

  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic relEvt;
    logic cmdEvt;
    logic sdaLevel;
  } lineEvents_t;
endpackage

// File: rtl/sbusLineDp.sv
module sbusLineDp
  import sbusPkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic        shiftStep,
  input  logic        shiftBit,
  input  drvStrobes_t drv,
  output lineEvents_t evt,
  output logic        latchQ,
  output logic        sdOut
);
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclNow, sdaNow, sclPrev, sdaPrev, sclHigh;

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclSync[s] <= 1'b1;
          sdaSync[s] <= 1'b1;
        end else begin
          sclSync[s] <= sclIn;
          sdaSync[s] <= sdaIn;
        end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) begin
          sclSync[s] <= 1'b1;
          sdaSync[s] <= 1'b1;
        end else begin
          sclSync[s] <= sclSync[s-1];
          sdaSync[s] <= sdaSync[s-1];
        end
    end
  end

  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end

  assign sclHigh      = sclNow & sclPrev;
  assign evt.sclRise  = sclNow & ~sclPrev;
  assign evt.sclFall  = ~sclNow & sclPrev;
  assign evt.relEvt   = sclHigh & sdaNow & ~sdaPrev;
  assign evt.cmdEvt   = sclHigh & ~sdaNow & sdaPrev;
  assign evt.sdaLevel = sdaNow;

  // Latch precedence: release, command, acknowledge hold, shift data.
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)                          latchQ <= 1'b1;
    else if (drv.forceHigh)             latchQ <= 1'b1;
    else if (drv.forceLow)              latchQ <= 1'b0;
    else if (!drv.ackLow && shiftStep)  latchQ <= shiftBit;

  assign sdOut = latchQ & ~drv.ackLow;
endmodule

// File: rtl/sbusCtlRegs.sv
module sbusCtlRegs
  import sbusPkg::*;
#(
  parameter int CNT_W     = 4,
  parameter int ACK_CLOCK = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrByte,
  input  logic              wrBit,
  input  logic [REG_W-1:0]  wrData,
  input  logic [$clog2(REG_W)-1:0] bitSel,
  input  logic              bitVal,
  input  logic              xferStart,
  input  logic              addrChk,
  input  logic              addrMatch,
  input  logic              wakeMode,
  input  logic              ifEnable,
  input  lineEvents_t       evt,
  output logic [REG_W-1:0]  rdData,
  output drvStrobes_t       drv
);
  localparam logic [CNT_W-1:0] ACK_IDX = CNT_W'(ACK_CLOCK - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic relTrig, cmdTrig, ackTrig, ackAuto, relSeen, cmdSeen, ackSeen, gpBit;
  logic ackPend, ackDrive;
  logic [CNT_W-1:0] riseCnt;
  logic [REG_W-1:0] cur, nextVal, wrMask, setVec;
  logic flush, bitsDone, autoHit, autoRise, mismatch;

  always_comb begin
    cur = '0;
    cur[REL_TRIG] = relTrig;
    cur[CMD_TRIG] = cmdTrig;
    cur[ACK_TRIG] = ackTrig;
    cur[ACK_AUTO] = ackAuto;
    cur[REL_SEEN] = relSeen;
    cur[CMD_SEEN] = cmdSeen;
    cur[ACK_SEEN] = ackSeen;
    cur[GP_BIT]   = gpBit;
    nextVal = cur;
    wrMask  = '0;
    if (wrByte) begin
      nextVal = wrData;
      wrMask  = '1;
    end else if (wrBit) begin
      nextVal[bitSel] = bitVal;
      wrMask[bitSel]  = 1'b1;
    end
    setVec = wrMask & nextVal;
    rdData = cur;
    rdData[REL_TRIG] = 1'b0;
    rdData[CMD_TRIG] = 1'b0;
    rdData[ACK_TRIG] = 1'b0;
  end

  assign flush    = ~ifEnable | xferStart;
  assign bitsDone = riseCnt >= ACK_IDX;
  assign autoHit  = ackAuto & (riseCnt == ACK_IDX);
  assign autoRise = setVec[ACK_AUTO] & ~ackAuto & bitsDone;
  assign mismatch = addrChk & ~addrMatch & wakeMode;

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      relTrig <= 1'b0; cmdTrig <= 1'b0; ackTrig <= 1'b0; ackAuto <= 1'b0;
      relSeen <= 1'b0; cmdSeen <= 1'b0; ackSeen <= 1'b0; gpBit   <= 1'b0;
      ackPend <= 1'b0; ackDrive <= 1'b0; riseCnt <= '0;
    end else begin
      // one-shot triggers: live for one cycle, dropped when disabled
      relTrig <= ifEnable & setVec[REL_TRIG];
      cmdTrig <= ifEnable & setVec[CMD_TRIG];
      if (wrMask[ACK_AUTO]) ackAuto <= nextVal[ACK_AUTO];
      if (wrMask[GP_BIT])   gpBit   <= nextVal[GP_BIT];

      if (flush)                  ackTrig <= 1'b0;
      else if (setVec[ACK_TRIG])  ackTrig <= 1'b1;
      else if (evt.sclFall)       ackTrig <= 1'b0;

      if (flush)                  ackPend <= 1'b0;
      else if (autoRise)          ackPend <= 1'b1;
      else if (evt.sclFall)       ackPend <= 1'b0;

      if (!ifEnable)              ackDrive <= 1'b0;
      else if (evt.sclFall)       ackDrive <= ackTrig | ackPend | autoHit;

      if (flush)                  riseCnt <= '0;
      else if (evt.sclRise && riseCnt != CNT_MAX) riseCnt <= riseCnt + 1'b1;

      if (flush | mismatch)       relSeen <= 1'b0;
      else if (evt.relEvt)        relSeen <= 1'b1;

      if (flush | evt.relEvt)     cmdSeen <= 1'b0;
      else if (evt.cmdEvt)        cmdSeen <= 1'b1;

      if (flush)                  ackSeen <= 1'b0;
      else if (evt.sclRise && riseCnt == ACK_IDX && !evt.sdaLevel) ackSeen <= 1'b1;
    end

  assign drv.forceHigh = relTrig;
  assign drv.forceLow  = cmdTrig;
  assign drv.ackLow    = ackDrive;
endmodule

// File: rtl/sbusCtrlStatus.sv
module sbusCtrlStatus
  import sbusPkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 4,
  parameter int ACK_CLOCK   = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrByte,
  input  logic       wrBit,
  input  logic [7:0] wrData,
  input  logic [2:0] bitSel,
  input  logic       bitVal,
  output logic [7:0] rdData,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic       shiftStep,
  input  logic       shiftBit,
  input  logic       xferStart,
  input  logic       addrChk,
  input  logic       addrMatch,
  input  logic       wakeMode,
  input  logic       ifEnable,
  output logic       sdOut
);
  drvStrobes_t drv;
  lineEvents_t evt;
  logic        latchQ;

  sbusCtlRegs #(.CNT_W(CNT_W), .ACK_CLOCK(ACK_CLOCK)) i_ctl (
    .clk, .rstN, .wrByte, .wrBit, .wrData, .bitSel, .bitVal,
    .xferStart, .addrChk, .addrMatch, .wakeMode, .ifEnable,
    .evt, .rdData, .drv
  );

  sbusLineDp #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk, .rstN, .sclIn, .sdaIn, .shiftStep, .shiftBit,
    .drv, .evt, .latchQ, .sdOut
  );
endmodule

// File: rtl/sbusCtrlStatusChk.sv
module sbusCtrlStatusChk
  import sbusPkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        ifEnable,
  input logic        xferStart,
  input logic [7:0]  rdData,
  input drvStrobes_t drv,
  input lineEvents_t evt,
  input logic        latchQ
);
  AST_REL_SETS_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    drv.forceHigh |=> latchQ); // R4
  AST_CMD_CLEARS_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    (drv.forceLow && !drv.forceHigh) |=> !latchQ); // R5
  AST_OFF_NO_TRIGGER: assert property (@(posedge clk) disable iff (!rstN)
    !ifEnable |=> (!drv.forceHigh && !drv.forceLow)); // R6
  AST_START_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> (rdData[6:4] == 3'b000)); // R7
  AST_REL_DROPS_CMD: assert property (@(posedge clk) disable iff (!rstN)
    evt.relEvt |=> !rdData[5]); // R8
  AST_ACK_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drv.ackLow) |-> $past(evt.sclFall)); // R9
  AST_OFF_CLEARS_ALL: assert property (@(posedge clk) disable iff (!rstN)
    !ifEnable |=> (rdData[6:4] == 3'b000 && !drv.ackLow)); // R13
endmodule

bind sbusCtrlStatus sbusCtrlStatusChk i_chk (
  .clk, .rstN, .ifEnable, .xferStart, .rdData, .drv, .evt, .latchQ
);

// File: tb/test_sbusCtrlStatus.sv
module test_sbusCtrlStatus;
  logic clk = 1'b0, rstN = 1'b0;
  logic wrByte = 0, wrBit = 0, bitVal = 0;
  logic [7:0] wrData = '0;
  logic [2:0] bitSel = '0;
  logic sclIn = 1, sdaIn = 1, shiftStep = 0, shiftBit = 0;
  logic xferStart = 0, addrChk = 0, addrMatch = 0, wakeMode = 0, ifEnable = 1;
  logic [7:0] rdData;
  logic sdOut;
  int vectors = 0, miscompares = 0;
  logic latchModel;

  always #4 clk = ~clk;

  sbusCtrlStatus i_sbusCtrlStatus (
    .clk, .rstN, .wrByte, .wrBit, .wrData, .bitSel, .bitVal, .rdData,
    .sclIn, .sdaIn, .shiftStep, .shiftBit, .xferStart, .addrChk,
    .addrMatch, .wakeMode, .ifEnable, .sdOut
  );

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic wrB(logic [7:0] v);
    wrByte = 1; wrData = v; tick(1);
    wrByte = 0; tick(1);
  endtask

  task automatic wrOne(logic [2:0] s, logic v);
    wrBit = 1; bitSel = s; bitVal = v; tick(1);
    wrBit = 0; tick(1);
  endtask

  task automatic setLines(logic c, logic d);
    sclIn = c; sdaIn = d; tick(4);
  endtask

  task automatic pulseStart();
    xferStart = 1; tick(1); xferStart = 0; tick(1);
  endtask

  task automatic pulseAddr(logic m, logic w);
    addrChk = 1; addrMatch = m; wakeMode = w; tick(1);
    addrChk = 0; tick(1);
  endtask

  task automatic clkBit(logic d);
    sclIn = 0; tick(4); sdaIn = d; tick(4); sclIn = 1; tick(4);
  endtask

  initial begin
    tick(3); rstN = 1; tick(1);
    chk("R1 reset rd", rdData, 8'h00);
    chk("R1 reset sdOut", {7'b0, sdOut}, 8'h01);

    // R2 / R4 / R5: exhaustive byte sweep
    latchModel = 1'b1;
    for (int v = 0; v < 256; v++) begin
      wrB(8'(v));
      if (v[0]) latchModel = 1'b1;
      else if (v[1]) latchModel = 1'b0;
      chk("R2 byte readback", rdData, 8'(v) & 8'h88);
      chk("R4/R5 trigger latch", {7'b0, sdOut}, {7'b0, latchModel});
    end
    pulseStart();

    // R3: single-bit writes over two base patterns
    for (int b = 0; b < 2; b++)
      for (int s = 0; s < 8; s++)
        for (int v = 0; v < 2; v++) begin
          logic [7:0] base, exp;
          base = b[0] ? 8'h88 : 8'h00;
          wrB(8'h01);
          wrB(base);
          wrOne(3'(s), v[0]);
          exp = base;
          exp[s] = v[0];
          chk("R3 bit write", rdData, exp & 8'h88);
          if (s == 0 && v == 1) chk("R3/R4 bit rel", {7'b0, sdOut}, 8'h01);
          if (s == 1 && v == 1) chk("R3/R5 bit cmd", {7'b0, sdOut}, 8'h00);
        end
    pulseStart();

    // R6: triggers ignored while disabled
    wrB(8'h02);
    chk("R5 cmd low", {7'b0, sdOut}, 8'h00);
    ifEnable = 0; tick(1);
    wrB(8'h01);
    chk("R6 disabled rel ignored", {7'b0, sdOut}, 8'h00);
    ifEnable = 1; tick(1);
    wrB(8'h01);
    chk("R6 enabled rel acts", {7'b0, sdOut}, 8'h01);

    // R14 and precedence against shift data
    wrB(8'h00);
    shiftStep = 1; shiftBit = 0; tick(1); shiftStep = 0; tick(1);
    chk("R14 shift 0", {7'b0, sdOut}, 8'h00);
    shiftStep = 1; shiftBit = 1; tick(1); shiftStep = 0; tick(1);
    chk("R14 shift 1", {7'b0, sdOut}, 8'h01);
    wrByte = 1; wrData = 8'h01; tick(1);
    wrByte = 0; shiftStep = 1; shiftBit = 0; tick(1);
    shiftStep = 0; tick(1);
    chk("R4 rel over shift", {7'b0, sdOut}, 8'h01);
    wrByte = 1; wrData = 8'h02; tick(1);
    wrByte = 0; shiftStep = 1; shiftBit = 1; tick(1);
    shiftStep = 0; tick(1);
    chk("R5 cmd over shift", {7'b0, sdOut}, 8'h00);
    wrB(8'h01);

    // R7 / R8: line detection
    setLines(1, 1); pulseStart();
    setLines(1, 0);
    chk("R8 cmd seen", rdData, 8'h20);
    setLines(1, 1);
    chk("R8 rel clears cmd, R7 rel seen", rdData, 8'h10);
    setLines(1, 0);
    chk("R8 cmd with rel", rdData, 8'h30);
    pulseStart();
    chk("R7/R8 start clears", rdData, 8'h00);
    setLines(1, 1);
    chk("R7 rel seen again", rdData, 8'h10);
    pulseAddr(0, 0);
    chk("R7 mismatch no wake keeps", rdData, 8'h10);
    pulseAddr(1, 1);
    chk("R7 match keeps", rdData, 8'h10);
    pulseAddr(0, 1);
    chk("R7 mismatch in wake clears", rdData, 8'h00);
    wakeMode = 0;

    // R13: disable clears flags
    setLines(1, 0); setLines(1, 1); setLines(1, 0);
    chk("R13 flags before off", rdData, 8'h30);
    ifEnable = 0; tick(1);
    chk("R13 flags off", rdData, 8'h00);
    ifEnable = 1; tick(1);

    // R9 / R12: transfer sweep over auto enable and ack line level
    for (int a = 0; a < 2; a++)
      for (int l = 0; l < 2; l++) begin
        setLines(1, 1); pulseStart();
        wrB(8'h01);
        wrB(a[0] ? 8'h08 : 8'h00);
        for (int b = 0; b < 8; b++) clkBit(b[0]);
        chk("R9 before ack clock", {7'b0, sdOut}, 8'h01);
        sclIn = 0; tick(4);
        chk("R9 ninth fall", {7'b0, sdOut}, a[0] ? 8'h00 : 8'h01);
        sdaIn = l[0]; tick(4);
        sclIn = 1; tick(4);
        chk("R12 ack seen", {7'b0, rdData[6]}, {7'b0, ~l[0]});
        chk("R9 held while high", {7'b0, sdOut}, a[0] ? 8'h00 : 8'h01);
        sclIn = 0; tick(4);
        chk("R9 released tenth fall", {7'b0, sdOut}, 8'h01);
        sclIn = 1; tick(4);
      end

    // R10: software acknowledge
    setLines(1, 1); pulseStart();
    wrB(8'h01);
    wrB(8'h04);
    chk("R10 trig reads 0", rdData, 8'h00);
    chk("R10 no fall yet", {7'b0, sdOut}, 8'h01);
    sclIn = 0; tick(4);
    chk("R10 ack on fall", {7'b0, sdOut}, 8'h00);
    sclIn = 1; tick(4);
    sclIn = 0; tick(4);
    chk("R10 ack ends", {7'b0, sdOut}, 8'h01);
    sclIn = 1; tick(4);

    // R11: enable after completion, and too early
    pulseStart();
    wrB(8'h01);
    for (int b = 0; b < 9; b++) clkBit(1'b1);
    wrB(8'h08);
    chk("R11 enable read", rdData, 8'h08);
    chk("R11 idle before fall", {7'b0, sdOut}, 8'h01);
    sclIn = 0; tick(4);
    chk("R11 ack next fall", {7'b0, sdOut}, 8'h00);
    sclIn = 1; tick(4);
    sclIn = 0; tick(4);
    chk("R11 ack ends", {7'b0, sdOut}, 8'h01);
    chk("R11 enable kept", rdData, 8'h08);
    sclIn = 1; tick(4);
    pulseStart();
    wrB(8'h01);
    for (int b = 0; b < 3; b++) clkBit(1'b1);
    wrB(8'h08);
    sclIn = 0; tick(4);
    chk("R11 early enable no ack", {7'b0, sdOut}, 8'h01);
    sclIn = 1; tick(4);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule